// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Two-Bit Instructions

This block is a test access port in the IEEE 1149.1 style. It sits between the core logic of a chip and its pads. A serial test clock, a mode-select line and a data input drive a sixteen-state controller. That controller steers serial bits either into a two-bit instruction register or into a data register. The instruction in force decides two things independently: which data register lies between the serial input and output, and whether the pads are driven by the core or by the latched outputs of a boundary register.

The boundary register has one cell per pad input and one per pad output. It can take a snapshot of live traffic, be preloaded while the core keeps running, and then take over the pads for board interconnect tests. There are two one-bit pass-through variants. One keeps the pads under test control and one leaves the device running normally. The second is the reset default.

Top module: `scan_tap`

## Requirements
- R1: The controller moves between the sixteen standard states on each rising TCK edge, following the sampled TMS. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state, and that state loads instruction 2'b11.
- R2: While `trst_n` is low, the controller is held in Test-Logic-Reset and the instruction is 2'b11 with no clock needed, so `pin_out` equals `core_out` at once. Internal release happens on the second rising TCK edge after `trst_n` rises.
- R3: In Capture-IR the instruction shifter loads 2'b01. It shifts out least significant bit first. A newly shifted instruction takes effect only on the falling TCK edge inside Update-IR.
- R4: Instruction 2'b11 selects the one-bit pass-through register, which loads 0 in Capture-DR. A shift of n bits returns 0 followed by the first n-1 input bits. The pads follow the core (`pin_out`=`core_out`, `core_in`=`pin_in`).
- R5: Instruction 2'b10 selects the same one-bit pass-through register, but `pin_out` and `core_in` come from the boundary latches.
- R6: Instruction 2'b01 selects the boundary register without disturbing the pads. Capture-DR loads `pin_in` into chain positions 0..NUM_IN-1 and `core_out` into positions NUM_IN..NUM_IN+NUM_OUT-1. Position 0 leaves first on TDO.
- R7: Instruction 2'b00 selects the boundary register and isolates the core. `pin_out` is taken from latch positions NUM_IN and up, and `core_in` from latch positions below NUM_IN. Changes on `core_out` do not reach `pin_out`.
- R8: The boundary latches change only on the falling TCK edge in Update-DR, and only under a boundary instruction (2'b00 or 2'b01). After a full shift, the latch at position k holds the k-th bit shifted in.
- R9: TDO and `tdo_en` change on the falling TCK edge. `tdo_en` is high exactly when the controller is in Shift-IR or Shift-DR, and low in Pause-DR and all other states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, valid when enabled |
| tdo_en | output | 1 | Output enable for TDO (high-impedance when low) |
| pin_in | input | NUM_IN | Values arriving from input pads |
| core_in | output | NUM_IN | Values presented to the core inputs |
| core_out | input | NUM_OUT | Values the core wants on its output pads |
| pin_out | output | NUM_OUT | Values driven to output pads |

## Verification
A controller state change is due on the rising edge where TMS is sampled. TDO and its enable follow half a period later, on the next falling edge. The instruction and the boundary latches also move on that falling edge, inside Update-IR or Update-DR, so the pads change half a period after the rising edge that enters an Update state. Only `trst_n` acts with no clock edge at all. Every bench step drives its inputs and samples the outputs a quarter period after a falling edge. Each sampled TDO bit is therefore the one presented for the rising edge about to occur, and the pad checks are made after the update edge has passed.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    TS_RESET    = 4'h0,
    TS_IDLE     = 4'h1,
    TS_SEL_DR   = 4'h2,
    TS_CAP_DR   = 4'h3,
    TS_SH_DR    = 4'h4,
    TS_EX1_DR   = 4'h5,
    TS_PAUSE_DR = 4'h6,
    TS_EX2_DR   = 4'h7,
    TS_UPD_DR   = 4'h8,
    TS_SEL_IR   = 4'h9,
    TS_CAP_IR   = 4'hA,
    TS_SH_IR    = 4'hB,
    TS_EX1_IR   = 4'hC,
    TS_PAUSE_IR = 4'hD,
    TS_EX2_IR   = 4'hE,
    TS_UPD_IR   = 4'hF
  } tap_state_e;

  // bit 1 low selects the boundary chain; bit 0 low hands pads to test latches
  typedef enum logic [1:0] {
    INS_EXTEST   = 2'b00,
    INS_SNAPSHOT = 2'b01,
    INS_PASS_TST = 2'b10,
    INS_PASS_RUN = 2'b11
  } tap_instr_e;

  localparam logic [1:0] IR_CAPTURE_PATTERN = 2'b01;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     state_d = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   state_d = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   state_d = tms ? TS_EX1_DR   : TS_SH_DR;
      TS_SH_DR:    state_d = tms ? TS_EX1_DR   : TS_SH_DR;
      TS_EX1_DR:   state_d = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: state_d = tms ? TS_EX2_DR   : TS_PAUSE_DR;
      TS_EX2_DR:   state_d = tms ? TS_UPD_DR   : TS_SH_DR;
      TS_UPD_DR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   state_d = tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   state_d = tms ? TS_EX1_IR   : TS_SH_IR;
      TS_SH_IR:    state_d = tms ? TS_EX1_IR   : TS_SH_IR;
      TS_EX1_IR:   state_d = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: state_d = tms ? TS_EX2_IR   : TS_PAUSE_IR;
      TS_EX2_IR:   state_d = tms ? TS_UPD_IR   : TS_SH_IR;
      TS_UPD_IR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
      default:     state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TS_RESET;
    else        state <= state_d;
  end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output tap_instr_e instr,
  output logic       ser_out
);

  logic [1:0] shf_q, shf_d;
  logic       cap_en, sh_en, upd_en, clr_en;

  assign cap_en = (state == TS_CAP_IR);
  assign sh_en  = (state == TS_SH_IR);
  assign upd_en = (state == TS_UPD_IR);
  assign clr_en = (state == TS_RESET);

  always_comb begin
    shf_d = shf_q;
    if (cap_en)     shf_d = IR_CAPTURE_PATTERN;
    else if (sh_en) shf_d = {tdi, shf_q[1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) shf_q <= IR_CAPTURE_PATTERN;
    else        shf_q <= shf_d;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      instr <= INS_PASS_RUN;
    else if (clr_en) instr <= INS_PASS_RUN;
    else if (upd_en) instr <= tap_instr_e'(shf_q);
  end

  assign ser_out = shf_q[0];

endmodule

// File: rtl/scan_tap_bsr.sv
module scan_tap_bsr #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic                      tck,
  input  logic                      rst_n,
  input  logic                      cap_en,
  input  logic                      sh_en,
  input  logic                      upd_en,
  input  logic                      tdi,
  input  logic [NUM_IN-1:0]         pin_in,
  input  logic [NUM_OUT-1:0]        core_out,
  output logic [NUM_IN+NUM_OUT-1:0] latch_q,
  output logic                      ser_out
);

  localparam int LEN = NUM_IN + NUM_OUT;

  logic [LEN-1:0] cap_val;
  logic [LEN-1:0] shf_q, shf_d;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    if (i < NUM_IN) begin : g_in
      assign cap_val[i] = pin_in[i];
    end else begin : g_out
      assign cap_val[i] = core_out[i-NUM_IN];
    end
  end

  always_comb begin
    shf_d = shf_q;
    if (cap_en)     shf_d = cap_val;
    else if (sh_en) shf_d = {tdi, shf_q[LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) shf_q <= '0;
    else        shf_q <= shf_d;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      latch_q <= '0;
    else if (upd_en) latch_q <= shf_q;
  end

  assign ser_out = shf_q[0];

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_en,
  input  logic [NUM_IN-1:0]  pin_in,
  output logic [NUM_IN-1:0]  core_in,
  input  logic [NUM_OUT-1:0] core_out,
  output logic [NUM_OUT-1:0] pin_out
);

  localparam int LEN = NUM_IN + NUM_OUT;

  logic [1:0]     rst_sync_q;
  logic           rst_n;
  tap_state_e     tap_state;
  tap_instr_e     active_ir;
  logic           ir_so, bsr_so, bypass_q, bypass_d;
  logic           bsr_sel, test_mode;
  logic [LEN-1:0] bsr_upd;
  logic           tdo_d, tdo_en_d;

  // asynchronous assertion, release on the second rising edge
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  scan_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (tap_state)
  );

  scan_tap_ir u_ir (
    .tck     (tck),
    .rst_n   (rst_n),
    .state   (tap_state),
    .tdi     (tdi),
    .instr   (active_ir),
    .ser_out (ir_so)
  );

  assign bsr_sel   = ~active_ir[1];
  assign test_mode = ~active_ir[0];

  scan_tap_bsr #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_bsr (
    .tck      (tck),
    .rst_n    (rst_n),
    .cap_en   (bsr_sel && (tap_state == TS_CAP_DR)),
    .sh_en    (bsr_sel && (tap_state == TS_SH_DR)),
    .upd_en   (bsr_sel && (tap_state == TS_UPD_DR)),
    .tdi      (tdi),
    .pin_in   (pin_in),
    .core_out (core_out),
    .latch_q  (bsr_upd),
    .ser_out  (bsr_so)
  );

  always_comb begin
    bypass_d = bypass_q;
    if (!bsr_sel && tap_state == TS_CAP_DR)     bypass_d = 1'b0;
    else if (!bsr_sel && tap_state == TS_SH_DR) bypass_d = tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) bypass_q <= 1'b0;
    else        bypass_q <= bypass_d;
  end

  always_comb begin
    tdo_d    = 1'b0;
    tdo_en_d = 1'b0;
    if (tap_state == TS_SH_IR) begin
      tdo_d    = ir_so;
      tdo_en_d = 1'b1;
    end else if (tap_state == TS_SH_DR) begin
      tdo_d    = bsr_sel ? bsr_so : bypass_q;
      tdo_en_d = 1'b1;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_en <= tdo_en_d;
    end
  end

  assign pin_out = test_mode ? bsr_upd[LEN-1:NUM_IN] : core_out;
  assign core_in = test_mode ? bsr_upd[NUM_IN-1:0]   : pin_in;

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input logic                      tck,
  input logic                      rst_n,
  input logic                      tms,
  input tap_state_e                st,
  input tap_instr_e                ir,
  input logic                      tdo_en,
  input logic [NUM_OUT-1:0]        pin_out,
  input logic [NUM_OUT-1:0]        core_out,
  input logic [NUM_IN+NUM_OUT-1:0] upd
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)         ones_cnt <= 3'd0;
    else if (!tms)      ones_cnt <= 3'd0;
    else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;
  end

  p_five_ones_r1: assert property (@(posedge tck) disable iff (!rst_n)
    (tms && ones_cnt >= 3'd4) |=> (st == TS_RESET));

  p_reset_instr_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (st == TS_RESET) |=> (ir == INS_PASS_RUN));

  p_ir_hold_r3: assert property (@(posedge tck) disable iff (!rst_n)
    !(st == TS_UPD_IR || st == TS_RESET) |-> (ir == $past(ir)));

  p_core_pins_r4: assert property (@(posedge tck) disable iff (!rst_n)
    (ir == INS_PASS_RUN) |-> (pin_out == core_out));

  p_extest_pins_r7: assert property (@(posedge tck) disable iff (!rst_n)
    (ir == INS_EXTEST) |-> (pin_out == upd[NUM_IN+NUM_OUT-1:NUM_IN]));

  p_latch_hold_r8: assert property (@(posedge tck) disable iff (!rst_n)
    (st != TS_UPD_DR) |-> $stable(upd));

  p_tdo_on_r9: assert property (@(posedge tck) disable iff (!rst_n)
    (st == TS_SH_DR || st == TS_SH_IR) |-> tdo_en);

  p_tdo_off_r9: assert property (@(posedge tck) disable iff (!rst_n)
    !(st == TS_SH_DR || st == TS_SH_IR) |-> !tdo_en);

endmodule

bind scan_tap scan_tap_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
  .tck      (tck),
  .rst_n    (rst_n),
  .tms      (tms),
  .st       (tap_state),
  .ir       (active_ir),
  .tdo_en   (tdo_en),
  .pin_out  (pin_out),
  .core_out (core_out),
  .upd      (bsr_upd)
);

// File: tb/scan_tap_tb.sv
module scan_tap_tb;

  localparam int TCK_PERIOD = 20;
  localparam int NI  = 4;
  localparam int NO  = 4;
  localparam int LEN = NI + NO;

  logic          tck, trst_n, tms, tdi;
  logic          tdo, tdo_en;
  logic [NI-1:0] pin_in, core_in;
  logic [NO-1:0] core_out, pin_out;

  int n_total;
  int n_bad;

  scan_tap #(.NUM_IN(NI), .NUM_OUT(NO)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_en(tdo_en),
    .pin_in(pin_in), .core_in(core_in),
    .core_out(core_out), .pin_out(pin_out)
  );

  initial tck = 1'b0;
  always #(TCK_PERIOD/2) tck = ~tck;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // capture order: pads in low positions, core outputs above
  function automatic logic [LEN-1:0] snap_exp(input logic [NI-1:0] pi, input logic [NO-1:0] co);
    return {co, pi};
  endfunction

  function automatic logic [31:0] bypass_exp(input logic [31:0] v, input int n);
    logic [31:0] r;
    r = '0;
    for (int i = 1; i < n; i++) r[i] = v[i-1];
    return r;
  endfunction

  // sample outputs for the coming rising edge, drive inputs, advance past the next falling edge
  task automatic step(input logic t_ms, input logic t_di, output logic so, output logic so_en);
    so    = tdo;
    so_en = tdo_en;
    tms   = t_ms;
    tdi   = t_di;
    @(posedge tck);
    @(negedge tck);
    #(TCK_PERIOD/4);
  endtask

  task automatic shift_ir(input logic [1:0] val, output logic [1:0] cap,
                          output logic [NO-1:0] pins_before_upd);
    logic so, en;
    step(1'b1, 1'b0, so, en);
    step(1'b1, 1'b0, so, en);
    step(1'b0, 1'b0, so, en);
    step(1'b0, 1'b0, so, en);
    for (int i = 0; i < 2; i++) begin
      step(i == 1, val[i], so, en);
      cap[i] = so;
      check("R9 tdo_en in Shift-IR", {31'd0, en}, 32'd1);
    end
    pins_before_upd = pin_out;
    step(1'b1, 1'b0, so, en);
    step(1'b0, 1'b0, so, en);
  endtask

  task automatic shift_dr(input logic [31:0] v, input int n, input logic watch,
                          input logic [NO-1:0] hold, output logic [31:0] got);
    logic so, en;
    got = '0;
    step(1'b1, 1'b0, so, en);
    check("R9 tdo_en off in Select-DR", {31'd0, en}, 32'd0);
    step(1'b0, 1'b0, so, en);
    step(1'b0, 1'b0, so, en);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, v[i], so, en);
      got[i] = so;
      if (i == 0) check("R9 tdo_en in Shift-DR", {31'd0, en}, 32'd1);
      if (watch) check("R8 pads held during shift", {24'd0, pin_out}, {24'd0, hold});
    end
    if (watch) check("R8 pads held before Update-DR", {24'd0, pin_out}, {24'd0, hold});
    step(1'b1, 1'b0, so, en);
    step(1'b0, 1'b0, so, en);
  endtask

  task automatic to_idle_after_release();
    logic so, en;
    trst_n = 1'b1;
    repeat (3) step(1'b1, 1'b0, so, en);
    step(1'b0, 1'b0, so, en);
  endtask

  initial begin
    logic [1:0]     cap;
    logic [NO-1:0]  pb;
    logic [31:0]    got, v;
    logic [LEN-1:0] pre, last_lat;
    logic           so, en;
    int unsigned    seed_init;

    n_total = 0;
    n_bad   = 0;
    seed_init = $urandom(32'd4242);
    tms = 1'b1; tdi = 1'b0; trst_n = 1'b0;
    pin_in = NI'($urandom); core_out = NO'($urandom);
    @(negedge tck);
    #(TCK_PERIOD/4);

    // R2: reset state
    check("R2 tdo_en low in reset", {31'd0, tdo_en}, 32'd0);
    check("R2 pads follow core in reset", {24'd0, pin_out}, {24'd0, core_out});
    check("R2 core_in follows pads in reset", {24'd0, core_in}, {24'd0, pin_in});
    to_idle_after_release();

    // R3: capture pattern, R4: default pass-through
    shift_ir(2'b11, cap, pb);
    check("R3 IR capture pattern", {30'd0, cap}, 32'd1);
    v = 32'($urandom) & 32'h3F;
    shift_dr(v, 6, 1'b0, '0, got);
    check("R4 one-bit pass-through", got & 32'h3F, bypass_exp(v, 6));
    core_out = NO'($urandom); pin_in = NI'($urandom); #1;
    check("R4 pads follow core", {24'd0, pin_out}, {24'd0, core_out});
    check("R4 core_in follows pads", {24'd0, core_in}, {24'd0, pin_in});

    // R6: snapshot/preload keeps pads on core
    shift_ir(2'b01, cap, pb);
    check("R3 second capture pattern", {30'd0, cap}, 32'd1);
    for (int k = 0; k < 6; k++) begin
      pin_in = NI'($urandom); core_out = NO'($urandom);
      pre = LEN'($urandom);
      if (k == 0) pre = '1;
      if (k == 1) pre = '0;
      shift_dr({24'd0, pre}, LEN, 1'b0, '0, got);
      check("R6 snapshot of pads and core", got, {24'd0, snap_exp(pin_in, core_out)});
      check("R6 pads stay on core", {24'd0, pin_out}, {24'd0, core_out});
      check("R6 core_in stays on pads", {24'd0, core_in}, {24'd0, pin_in});
      last_lat = pre;
    end

    // R3: instruction switches only at Update-IR; R7: external test
    core_out = ~last_lat[LEN-1:NI]; #1;
    shift_ir(2'b00, cap, pb);
    check("R3 old instruction until Update-IR", {24'd0, pb}, {24'd0, core_out});
    check("R7 pads from latches", {24'd0, pin_out}, {24'd0, last_lat[LEN-1:NI]});
    check("R7 core_in from latches", {24'd0, core_in}, {24'd0, last_lat[NI-1:0]});
    for (int k = 0; k < 5; k++) begin
      pre = LEN'($urandom);
      shift_dr({24'd0, pre}, LEN, 1'b1, last_lat[LEN-1:NI], got);
      check("R8 latches after update", {24'd0, pin_out, core_in}, {24'd0, pre[LEN-1:NI], pre[NI-1:0]});
      core_out = NO'($urandom); #1;
      check("R7 core_out ignored", {24'd0, pin_out}, {24'd0, pre[LEN-1:NI]});
      last_lat = pre;
    end

    // R5: pass-through with test mode kept
    shift_ir(2'b10, cap, pb);
    check("R5 pads still from latches", {24'd0, pin_out}, {24'd0, last_lat[LEN-1:NI]});
    v = 32'($urandom) & 32'h1F;
    shift_dr(v, 5, 1'b1, last_lat[LEN-1:NI], got);
    check("R5 one-bit pass-through", got & 32'h1F, bypass_exp(v, 5));
    check("R8 no update under pass-through", {24'd0, pin_out, core_in},
          {24'd0, last_lat[LEN-1:NI], last_lat[NI-1:0]});

    // R1: five ones from Pause-DR; R9: enable low while paused
    step(1'b1, 1'b0, so, en);
    step(1'b0, 1'b0, so, en);
    step(1'b0, 1'b0, so, en);
    step(1'b1, 1'b0, so, en);
    step(1'b0, 1'b0, so, en);
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b0, so, en);
      if (i == 0) check("R9 tdo_en low in Pause-DR", {31'd0, en}, 32'd0);
    end
    core_out = NO'($urandom); #1;
    check("R1 five ones restore default", {24'd0, pin_out}, {24'd0, core_out});
    step(1'b0, 1'b0, so, en);
    v = 32'($urandom) & 32'hF;
    shift_dr(v, 4, 1'b0, '0, got);
    check("R1 pass-through after reset walk", got & 32'hF, bypass_exp(v, 4));

    // R2: asynchronous test reset in the middle of external test
    shift_ir(2'b00, cap, pb);
    check("R7 external test re-entered", {24'd0, pin_out}, {24'd0, last_lat[LEN-1:NI]});
    core_out = ~last_lat[LEN-1:NI];
    #(TCK_PERIOD/8);
    trst_n = 1'b0;
    #1;
    check("R2 async reset frees pads", {24'd0, pin_out}, {24'd0, core_out});
    @(negedge tck);
    #(TCK_PERIOD/4);
    to_idle_after_release();
    check("R2 pads on core after release", {24'd0, pin_out}, {24'd0, core_out});
    shift_ir(2'b11, cap, pb);
    check("R3 capture after reset", {30'd0, cap}, 32'd1);

    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    #(TCK_PERIOD * 100000);
    n_total++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule